// File: doc/BRIEF.md
# Secure-Banked Private Interrupt State Registers

This block keeps the per-processor state of the private interrupts that belong to one processor: 16 software-generated interrupts (numbers 0 to 15) and 16 peripheral interrupts (numbers 16 to 31). For each interrupt it stores a group bit, a group-modifier bit, enable, pending and active flags, an 8-bit priority and a trigger type. Each software-generated interrupt also has a 2-bit non-secure access field. A simple 32-bit register bus reads and writes the state. Each access carries a secure flag. A global security-disable input selects between a two-world and a single-world system.

Every per-interrupt field is filtered by the interrupt's effective group. When security is enabled, a non-secure master cannot see secure interrupts. For non-secure interrupts it sees the priority through a halved view. The decoded effective group and the raw state drive the priority selector next to the block. A strobe tells that selector when software has raised pending bits.

Reads are combinational in the cycle the request is presented. Writes take effect at the next clock edge.

Top module: `irq_bank_regs`

## Requirements
- R1: After reset, the following are all zero: group, modifier, enable, pending, active, priority, access-control and peripheral trigger bits. The sleep flag is 1, and the software-generated interrupts report edge trigger.
- R2: Enable, pending and active each have a set register and a clear register. Set is at 0x100, 0x200 and 0x300; clear is at 0x180, 0x280 and 0x380; bit n is interrupt n. A 1 sets or clears the bit and a 0 leaves it unchanged. Both addresses read the current state.
- R3: The effective group is encoded as 0 for secure group 0, 1 for secure group 1 and 2 for non-secure group 1. With security enabled, group 1 gives 2 and group 0 gives 1 or 0 from the modifier bit. With security disabled, group 1 gives 2 and group 0 gives 0. The effective group of interrupt n is on eff_grp_o bits [2n+1:2n].
- R4: With security enabled and a non-secure access, every per-interrupt field of an interrupt whose effective group is not 2 reads as zero and ignores writes.
- R5: Priorities sit one byte per interrupt at 0x400 to 0x41C. Byte b of the word at 0x400+4w belongs to interrupt 4w+b. A non-secure access with security enabled stores 0x80 OR (data >> 1) and reads (stored << 1) truncated to 8 bits. Any other access stores and reads the byte unchanged.
- R6: The group register (0x080) reads as zero and ignores writes when the access is non-secure and security is enabled. The modifier register (0xD00) and the access-control register (0xE00, 2 bits per software-generated interrupt, bits [2n+1:2n] for interrupt n) read as zero and ignore writes unless the access is secure and security is enabled.
- R7: The trigger registers hold 2 bits per interrupt, and bit 2j+1 set means edge. 0xC00 covers interrupts 0 to 15, which always read as edge and ignore writes. 0xC04 covers interrupts 16 to 31 and is writable, subject to R4.
- R8: The wake register (0xA14) reads 0x6 (bit 1 sleep, bit 2 children asleep) while the sleep flag is 1 and reads 0 otherwise. A write loads the sleep flag from data bit 1. With security enabled, a non-secure access reads zero and is ignored.
- R9: Every write to the set-pending address raises upd_o for exactly the one cycle after the write edge.
- R10: An access to any address not listed in R2 to R8, including a misaligned one, returns zero and raises err_o in the same cycle. A listed address does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Access is from a secure master |
| sec_dis_i | input | 1 | Global security disable |
| rdata_o | output | 32 | Read data, combinational |
| err_o | output | 1 | Unmapped access |
| enable_o | output | NUM_IRQ | Enable flags |
| pending_o | output | NUM_IRQ | Pending flags |
| active_o | output | NUM_IRQ | Active flags |
| edge_o | output | NUM_IRQ | 1 = edge-triggered |
| eff_grp_o | output | 2*NUM_IRQ | Effective group per interrupt |
| prio_o | output | 8*NUM_IRQ | Stored priority per interrupt |
| nsacc_o | output | 2*NUM_SGI | Non-secure access field per software-generated interrupt |
| sleep_o | output | 1 | Processor sleep flag |
| upd_o | output | 1 | Pending-raised strobe |

## Verification
The bench builds the block with its defaults, 16 software-generated and 16 peripheral interrupts. At this size every interrupt fits in one bitmask word, so each register can be compared in full after every write.

A bench model is first loaded with a mixed group and modifier layout, so that all three effective groups are present. All four combinations of secure flag and security disable are then swept with several data patterns. After each write every mapped register is read twice: once in the current view and once in a fully privileged view. This exposes both the filtered view and the underlying stored state, including the halved non-secure priority view and the ignored writes.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    GRP_S0  = 2'd0,
    GRP_S1  = 2'd1,
    GRP_NS1 = 2'd2
  } eff_grp_e;

  localparam logic [11:0] OFF_WAKE  = 12'hA14;
  localparam logic [11:0] OFF_GRP   = 12'h080;
  localparam logic [11:0] OFF_SETEN = 12'h100;
  localparam logic [11:0] OFF_CLREN = 12'h180;
  localparam logic [11:0] OFF_SETP  = 12'h200;
  localparam logic [11:0] OFF_CLRP  = 12'h280;
  localparam logic [11:0] OFF_SETA  = 12'h300;
  localparam logic [11:0] OFF_CLRA  = 12'h380;
  localparam logic [11:0] OFF_PRIO  = 12'h400;
  localparam logic [11:0] OFF_CFG0  = 12'hC00;
  localparam logic [11:0] OFF_CFG1  = 12'hC04;
  localparam logic [11:0] OFF_GMOD  = 12'hD00;
  localparam logic [11:0] OFF_NSAC  = 12'hE00;
endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
  import irq_bank_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]      grp_i,
  input  logic [N-1:0]      gmod_i,
  input  logic              sec_dis_i,
  output logic [N-1:0][1:0] eff_o
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    always_comb begin
      if (grp_i[i])       eff_o[i] = GRP_NS1;
      else if (sec_dis_i) eff_o[i] = GRP_S0;
      else if (gmod_i[i]) eff_o[i] = GRP_S1;
      else                eff_o[i] = GRP_S0;
    end
  end
endmodule

// File: rtl/irq_bitvec_sc.sv
module irq_bitvec_sc #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | mask_i;
    else if (clr_i) q_o <= q_o & ~mask_i;
  end

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(mask_i)) == $past(mask_i)));
  a_r2_clr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(mask_i)) == '0));
endmodule

// File: rtl/irq_prio_lane.sv
module irq_prio_lane (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       ns_view_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] prio_o,
  output logic [7:0] view_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prio_o <= '0;
    else if (wr_i) prio_o <= ns_view_i ? {1'b1, wbyte_i[7:1]} : wbyte_i;
  end

  // non-secure view is the stored byte doubled
  assign view_o = ns_view_i ? {prio_o[6:0], 1'b0} : prio_o;

  a_r5_ns_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ns_view_i) |=> prio_o[7]);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(prio_o));
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_bank_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  parameter int ADDR_W  = 12,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 secure_i,
  input  logic                 sec_dis_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 err_o,
  output logic [NUM_IRQ-1:0]   enable_o,
  output logic [NUM_IRQ-1:0]   pending_o,
  output logic [NUM_IRQ-1:0]   active_o,
  output logic [NUM_IRQ-1:0]   edge_o,
  output logic [2*NUM_IRQ-1:0] eff_grp_o,
  output logic [8*NUM_IRQ-1:0] prio_o,
  output logic [2*NUM_SGI-1:0] nsacc_o,
  output logic                 sleep_o,
  output logic                 upd_o
);
  localparam int PRIO_WORDS = (NUM_IRQ + 3) / 4;

  logic wr;
  logic hit_wake, hit_grp, hit_seten, hit_clren, hit_setp, hit_clrp;
  logic hit_seta, hit_clra, hit_prio, hit_cfg0, hit_cfg1, hit_gmod, hit_nsac;
  logic mapped;
  logic [ADDR_W-1:0] prio_off;
  logic [ADDR_W-3:0] prio_word;

  assign wr        = req_i & we_i;
  assign hit_wake  = addr_i == ADDR_W'(OFF_WAKE);
  assign hit_grp   = addr_i == ADDR_W'(OFF_GRP);
  assign hit_seten = addr_i == ADDR_W'(OFF_SETEN);
  assign hit_clren = addr_i == ADDR_W'(OFF_CLREN);
  assign hit_setp  = addr_i == ADDR_W'(OFF_SETP);
  assign hit_clrp  = addr_i == ADDR_W'(OFF_CLRP);
  assign hit_seta  = addr_i == ADDR_W'(OFF_SETA);
  assign hit_clra  = addr_i == ADDR_W'(OFF_CLRA);
  assign hit_cfg0  = addr_i == ADDR_W'(OFF_CFG0);
  assign hit_cfg1  = addr_i == ADDR_W'(OFF_CFG1);
  assign hit_gmod  = addr_i == ADDR_W'(OFF_GMOD);
  assign hit_nsac  = addr_i == ADDR_W'(OFF_NSAC);
  assign prio_off  = addr_i - ADDR_W'(OFF_PRIO);
  assign prio_word = prio_off[ADDR_W-1:2];
  assign hit_prio  = (addr_i >= ADDR_W'(OFF_PRIO)) &&
                     (prio_off < ADDR_W'(4 * PRIO_WORDS)) && (addr_i[1:0] == 2'b00);

  assign mapped = hit_wake | hit_grp | hit_seten | hit_clren | hit_setp | hit_clrp |
                  hit_seta | hit_clra | hit_prio | hit_cfg0 | hit_cfg1 | hit_gmod | hit_nsac;
  assign err_o  = req_i & ~mapped;

  // access classes
  logic acc_priv, acc_sec_only, ns_view;
  assign acc_priv     = sec_dis_i | secure_i;
  assign acc_sec_only = ~sec_dis_i & secure_i;
  assign ns_view      = ~sec_dis_i & ~secure_i;

  logic [NUM_IRQ-1:0] grp_q, gmod_q;
  logic [NUM_IRQ-1:0][1:0] eff;
  logic [NUM_IRQ-1:0] vis, wmask;

  irq_grp_decode #(.N(NUM_IRQ)) u_dec (
    .grp_i     (grp_q),
    .gmod_i    (gmod_q),
    .sec_dis_i (sec_dis_i),
    .eff_o     (eff)
  );
  assign eff_grp_o = eff;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_vis
    assign vis[i] = ~ns_view | (eff[i] == GRP_NS1);
  end
  assign wmask = wdata_i[NUM_IRQ-1:0] & vis;

  irq_bitvec_sc #(.N(NUM_IRQ)) u_en (
    .clk_i, .rst_ni, .set_i(wr & hit_seten), .clr_i(wr & hit_clren),
    .mask_i(wmask), .q_o(enable_o)
  );
  irq_bitvec_sc #(.N(NUM_IRQ)) u_pend (
    .clk_i, .rst_ni, .set_i(wr & hit_setp), .clr_i(wr & hit_clrp),
    .mask_i(wmask), .q_o(pending_o)
  );
  irq_bitvec_sc #(.N(NUM_IRQ)) u_act (
    .clk_i, .rst_ni, .set_i(wr & hit_seta), .clr_i(wr & hit_clra),
    .mask_i(wmask), .q_o(active_o)
  );

  logic [7:0] prio_view [NUM_IRQ];
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    irq_prio_lane u_lane (
      .clk_i,
      .rst_ni,
      .wr_i      (wr & hit_prio & (prio_word == (ADDR_W-2)'(i / 4)) & vis[i]),
      .ns_view_i (ns_view),
      .wbyte_i   (wdata_i[8*(i%4) +: 8]),
      .prio_o    (prio_o[8*i +: 8]),
      .view_o    (prio_view[i])
    );
  end

  logic [NUM_PPI-1:0]   edge_ppi_q;
  logic [2*NUM_SGI-1:0] nsac_q;
  logic                 sleep_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q   <= '0;
      gmod_q  <= '0;
      nsac_q  <= '0;
      sleep_q <= 1'b1;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= wr & hit_setp;
      if (wr && hit_grp && acc_priv)      grp_q   <= wdata_i[NUM_IRQ-1:0];
      if (wr && hit_gmod && acc_sec_only) gmod_q  <= wdata_i[NUM_IRQ-1:0];
      if (wr && hit_nsac && acc_sec_only) nsac_q  <= wdata_i[2*NUM_SGI-1:0];
      if (wr && hit_wake && acc_priv)     sleep_q <= wdata_i[1];
    end
  end

  for (genvar j = 0; j < NUM_PPI; j++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) edge_ppi_q[j] <= 1'b0;
      else if (wr && hit_cfg1 && vis[NUM_SGI+j]) edge_ppi_q[j] <= wdata_i[2*j+1];
    end
  end

  assign edge_o  = {edge_ppi_q, {NUM_SGI{1'b1}}};
  assign nsacc_o = nsac_q;
  assign sleep_o = sleep_q;
  assign upd_o   = upd_q;

  always_comb begin
    rdata_o = '0;
    if (hit_wake) begin
      if (acc_priv && sleep_q) rdata_o[2:1] = 2'b11;
    end else if (hit_grp) begin
      if (acc_priv) rdata_o[NUM_IRQ-1:0] = grp_q;
    end else if (hit_seten || hit_clren) begin
      rdata_o[NUM_IRQ-1:0] = enable_o & vis;
    end else if (hit_setp || hit_clrp) begin
      rdata_o[NUM_IRQ-1:0] = pending_o & vis;
    end else if (hit_seta || hit_clra) begin
      rdata_o[NUM_IRQ-1:0] = active_o & vis;
    end else if (hit_cfg0) begin
      for (int j = 0; j < NUM_SGI; j++) rdata_o[2*j+1] = vis[j];
    end else if (hit_cfg1) begin
      for (int j = 0; j < NUM_PPI; j++) rdata_o[2*j+1] = edge_ppi_q[j] & vis[NUM_SGI+j];
    end else if (hit_gmod) begin
      if (acc_sec_only) rdata_o[NUM_IRQ-1:0] = gmod_q;
    end else if (hit_nsac) begin
      if (acc_sec_only) rdata_o[2*NUM_SGI-1:0] = nsac_q;
    end else if (hit_prio) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (prio_word == (ADDR_W-2)'(i / 4) && vis[i]) rdata_o[8*(i%4) +: 8] = prio_view[i];
    end
  end

  a_r9_upd_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(req_i && we_i && addr_i == ADDR_W'(OFF_SETP)));
  a_r10_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  a_r8_wake_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit_wake && !sec_dis_i && !secure_i) |-> (rdata_o == '0));
  a_r6_gmod_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_gmod && !acc_sec_only) |=> $stable(gmod_q));
  a_r6_grp_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_grp && !acc_priv) |=> $stable(grp_q));
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    a_r3_ns1_iff_grp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eff_grp_o[2*i +: 2] == GRP_NS1) == grp_q[i]);
  end
endmodule

// File: tb/test_irq_bank_regs.sv
module test_irq_bank_regs;
  localparam logic [11:0] A_WAKE = 12'hA14, A_GRP = 12'h080, A_SEN = 12'h100, A_CEN = 12'h180;
  localparam logic [11:0] A_SP = 12'h200, A_CP = 12'h280, A_SA = 12'h300, A_CA = 12'h380;
  localparam logic [11:0] A_PRIO = 12'h400, A_CFG0 = 12'hC00, A_CFG1 = 12'hC04;
  localparam logic [11:0] A_GMOD = 12'hD00, A_NSAC = 12'hE00;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, sd = 0, sec = 1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err, sleep, upd;
  logic [31:0] en_o, pend_o, act_o, edge_w;
  logic [63:0] eff_o;
  logic [255:0] prio_w;
  logic [31:0] nsacc_w;

  always #2.5 clk = ~clk;

  irq_bank_regs i_irq_bank_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .secure_i(sec), .sec_dis_i(sd), .rdata_o(rdata), .err_o(err),
    .enable_o(en_o), .pending_o(pend_o), .active_o(act_o), .edge_o(edge_w),
    .eff_grp_o(eff_o), .prio_o(prio_w), .nsacc_o(nsacc_w), .sleep_o(sleep), .upd_o(upd)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model
  logic [31:0] m_grp = 0, m_gmod = 0, m_en = 0, m_pend = 0, m_act = 0, m_nsac = 0;
  logic [31:0] m_edge = 32'h0000FFFF;
  logic [7:0]  m_prio [32];
  logic        m_sleep = 1;

  task automatic chk(string tag, string what, logic [63:0] a, logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  function automatic logic [1:0] m_eff(int i);
    if (m_grp[i]) return 2'd2;
    if (sd) return 2'd0;
    return m_gmod[i] ? 2'd1 : 2'd0;
  endfunction

  function automatic bit m_vis(int i);
    return sd || sec || (m_eff(i) == 2'd2);
  endfunction

  function automatic logic [31:0] vmask();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = m_vis(i);
    return v;
  endfunction

  function automatic bit is_prio(logic [11:0] a);
    return a >= A_PRIO && a < A_PRIO + 12'h20 && a[1:0] == 2'b00;
  endfunction

  function automatic void m_write(logic [11:0] a, logic [31:0] d);
    logic [31:0] v;
    bit ns;
    v = vmask();
    ns = !sd && !sec;
    if (is_prio(a)) begin
      for (int b = 0; b < 4; b++) begin
        int k;
        k = int'((a - A_PRIO) >> 2) * 4 + b;
        if (m_vis(k)) m_prio[k] = ns ? (8'h80 | (d[8*b +: 8] >> 1)) : d[8*b +: 8];
      end
    end else
      case (a)
        A_WAKE: if (sd || sec) m_sleep = d[1];
        A_GRP:  if (sd || sec) m_grp = d;
        A_SEN:  m_en   = m_en | (d & v);
        A_CEN:  m_en   = m_en & ~(d & v);
        A_SP:   m_pend = m_pend | (d & v);
        A_CP:   m_pend = m_pend & ~(d & v);
        A_SA:   m_act  = m_act | (d & v);
        A_CA:   m_act  = m_act & ~(d & v);
        A_CFG1: for (int j = 0; j < 16; j++) if (v[16+j]) m_edge[16+j] = d[2*j+1];
        A_GMOD: if (!sd && sec) m_gmod = d;
        A_NSAC: if (!sd && sec) m_nsac = d;
        default: ;
      endcase
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] r, v;
    v = vmask();
    r = '0;
    if (is_prio(a)) begin
      for (int b = 0; b < 4; b++) begin
        int k;
        k = int'((a - A_PRIO) >> 2) * 4 + b;
        if (m_vis(k)) r[8*b +: 8] = (!sd && !sec) ? {m_prio[k][6:0], 1'b0} : m_prio[k];
      end
      return r;
    end
    case (a)
      A_WAKE: r = ((sd || sec) && m_sleep) ? 32'h6 : 32'h0;
      A_GRP:  r = (sd || sec) ? m_grp : 32'h0;
      A_SEN, A_CEN: r = m_en & v;
      A_SP, A_CP:   r = m_pend & v;
      A_SA, A_CA:   r = m_act & v;
      A_CFG0: for (int j = 0; j < 16; j++) r[2*j+1] = v[j];
      A_CFG1: for (int j = 0; j < 16; j++) r[2*j+1] = m_edge[16+j] & v[16+j];
      A_GMOD: r = (!sd && sec) ? m_gmod : 32'h0;
      A_NSAC: r = (!sd && sec) ? m_nsac : 32'h0;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (is_prio(a)) return "R5";
    case (a)
      A_WAKE: return "R8";
      A_GRP, A_GMOD, A_NSAC: return "R6";
      A_CFG0, A_CFG1: return "R7";
      default: return "R2/R4";
    endcase
  endfunction

  task automatic set_mode(logic s_d, logic s);
    @(negedge clk);
    sd = s_d;
    sec = s;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1;
    d = rdata; e = err;
    req = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    req = 0; we = 0;
    m_write(a, d);
    chk("R9", "strobe after write", upd, a == A_SP);
    @(posedge clk);
    #1;
    chk("R9", "strobe falls", upd, 0);
  endtask

  task automatic check_view();
    logic [31:0] d;
    logic e;
    logic [63:0] ee;
    logic [11:0] list [20];
    list = '{A_WAKE, A_GRP, A_SEN, A_CEN, A_SP, A_CP, A_SA, A_CA,
             12'h400, 12'h404, 12'h408, 12'h40C, 12'h410, 12'h414, 12'h418, 12'h41C,
             A_CFG0, A_CFG1, A_GMOD, A_NSAC};
    foreach (list[n]) begin
      rd(list[n], d, e);
      chk(tag_of(list[n]), $sformatf("read %h sd=%0d sec=%0d", list[n], sd, sec), d, m_read(list[n]));
      chk("R10", "no err on mapped", e, 0);
    end
    for (int i = 0; i < 32; i++) ee[2*i +: 2] = m_eff(i);
    chk("R3", $sformatf("eff group sd=%0d", sd), eff_o, ee);
    chk("R2", "enable_o", en_o, m_en);
    chk("R2", "pending_o", pend_o, m_pend);
    chk("R2", "active_o", act_o, m_act);
    chk("R7", "edge_o", edge_w, m_edge);
    chk("R8", "sleep_o", sleep, m_sleep);
    chk("R6", "nsacc_o", nsacc_w, m_nsac);
  endtask

  task automatic op(logic [11:0] a, logic [31:0] d);
    logic s_d, s;
    wr(a, d);
    check_view();
    s_d = sd; s = sec;
    set_mode(0, 1);
    check_view();
    set_mode(s_d, s);
  endtask

  task automatic do_ops(logic [31:0] p);
    op(A_SEN, p);
    op(A_CEN, {p[28:0], p[31:29]});
    op(A_SP, p);
    op(A_CP, ~p);
    op(A_SA, p);
    op(A_CA, p ^ 32'h33333333);
    for (int w = 0; w < 8; w++) op(A_PRIO + 12'(4 * w), p + 32'h01030507 * w);
    op(A_CFG0, 32'h0);
    op(A_CFG1, p);
    op(A_WAKE, 32'h0);
    op(A_WAKE, 32'h2);
    op(A_NSAC, p);
    op(A_GMOD, ~p);
    op(A_GRP, p);
  endtask

  initial begin
    logic [31:0] pats [3];
    logic [11:0] bad [5];
    logic [31:0] d;
    logic e;
    for (int i = 0; i < 32; i++) m_prio[i] = 8'h00;
    pats = '{32'hFFFFFFFF, 32'h5A5A5A5A, 32'h0F0F00FF};
    bad  = '{12'h004, 12'h7FC, 12'h402, 12'hC08, 12'hFFC};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state in fully privileged view
    check_view();
    chk("R1", "edge_o reset", edge_w, 32'h0000FFFF);
    chk("R1", "sleep_o reset", sleep, 1);
    for (int m = 0; m < 4; m++) begin
      foreach (pats[q]) begin
        set_mode(0, 1);
        wr(A_GRP, 32'hF0F0F0F0);
        wr(A_GMOD, 32'hCCCCCCCC);
        set_mode(m[1], m[0]);
        do_ops(pats[q]);
      end
    end
    // R10 unmapped
    set_mode(0, 1);
    foreach (bad[n]) begin
      rd(bad[n], d, e);
      chk("R10", $sformatf("err at %h", bad[n]), e, 1);
      chk("R10", $sformatf("zero at %h", bad[n]), d, 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule